// File: doc/BRIEF.md
# Multi-Level Power Mode Controller

This block sequences the clock-enable outputs of an embedded processor subsystem through five ordered power levels. Software asks for a level by writing a 3-bit code. The block then closes or reopens six gateable clock domains, one domain per cycle, and reports its progress through a small status view. The six domains are CPU, system bus, DMA, auxiliary clocks, peripherals and a general timer domain. The real-time clock and memory refresh enables stay on at all times. A separate divider-select output puts the CPU into a reduced-speed mode. That mode slows the clock without gating any domain.

Each deeper level gates a strictly larger set of domains. Full speed and low speed gate nothing. Doze gates three domains, sleep gates five and suspend gates all six. In doze, sleep or suspend, an enabled wake line brings the block back to full speed and records which lines caused the wake. A management interrupt moves the block into a management state from any level, with every domain running at full speed. A resume command then restores the level that was held when the interrupt arrived.

Top module: `pwr_level_ctrl`

## Requirements
- R1: After reset the mode is full speed (0). All six `clk_en` bits are 1, `cpu_div_sel` is 0, and `status_busy`, `in_mgmt` and `wake_cause` are all 0.
- R2: A write with `mode_wdata` of 0 (full), 1 (low speed), 2 (doze), 3 (sleep) or 4 (suspend) sets `status_mode` to that code after the next edge. Codes 5, 6 and 7 leave the mode, the enables and `wake_cause` unchanged.
- R3: `clk_en` bit positions are 0 CPU, 1 bus, 2 DMA, 3 auxiliary, 4 peripheral, 5 timer. Once settled, doze clears bits 0..2, sleep clears bits 0..4 and suspend clears bits 0..5. Full speed and low speed clear none.
- R4: The enables change by at most one bit per cycle, starting the cycle after the mode register changes. Going deeper clears the lowest set bit first. Going shallower sets the highest cleared bit first. A new target that arrives mid-sequence redirects the walk from where it stands.
- R5: `status_busy` is 1 exactly while the enables differ from the settled pattern of the present target.
- R6: `cpu_div_sel` equals the parameter `LOW_DIV` while the mode is low speed (1) and the block is not in the management state. Otherwise it is 0.
- R7: In doze, sleep or suspend outside the management state, a cycle with any bit of `wake_evt & wake_en` set returns the mode to 0 and ORs those bits into `wake_cause`. Disabled lines, and any line in modes 0 or 1, have no effect. An accepted mode write clears `wake_cause`.
- R8: `mgmt_irq` sets `in_mgmt` from any mode. While `in_mgmt` is set, the target is all domains enabled and `status_mode` keeps the interrupted mode. A second `mgmt_irq` during the management state is ignored.
- R9: `resume_cmd` during the management state clears `in_mgmt`, so the held mode becomes the target again. A valid write during the management state replaces the held mode. `resume_cmd` outside the management state has no effect.
- R10: `rtc_clk_en` and `mem_clk_en` are 1 in every mode and state.
- R11: When several inputs act in the same cycle, the order of precedence is `mgmt_irq` (outside management), then a wake, then a mode write. Within the management state, `resume_cmd` wins over a write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_wr | input | 1 | Mode write strobe |
| mode_wdata | input | 3 | Requested mode code |
| mgmt_irq | input | 1 | Management interrupt |
| resume_cmd | input | 1 | Leave management state |
| wake_evt | input | NWAKE | Wake event lines |
| wake_en | input | NWAKE | Per-line wake enable |
| clk_en | output | 6 | Gateable domain clock enables |
| rtc_clk_en | output | 1 | Real-time clock enable |
| mem_clk_en | output | 1 | Memory refresh clock enable |
| cpu_div_sel | output | DIVW | CPU divider select |
| status_mode | output | 3 | Current (or held) mode |
| status_busy | output | 1 | Enable sequence in progress |
| in_mgmt | output | 1 | Management state active |
| wake_cause | output | NWAKE | Sticky wake lines that fired |

## Verification
The hardest situation to reach is a redirected sequence: a new target, a wake or a management interrupt arriving while the enables are still only part of the way through a walk. Collisions of several inputs in one cycle are equally hard. The bench sweeps every source mode against every written code. It also issues a second command two cycles into a suspend entry, and drives wake lines, interrupts and resumes both together and against half-finished sequences. At every cycle a per-cycle model built from the requirements predicts the enable count.

// File: rtl/pwr_level_ctrl.sv
module pwr_level_ctrl #(
  parameter int NWAKE   = 4,
  parameter int DIVW    = 4,
  parameter int LOW_DIV = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_wr,
  input  logic [2:0]       mode_wdata,
  input  logic             mgmt_irq,
  input  logic             resume_cmd,
  input  logic [NWAKE-1:0] wake_evt,
  input  logic [NWAKE-1:0] wake_en,
  output logic [5:0]       clk_en,
  output logic             rtc_clk_en,
  output logic             mem_clk_en,
  output logic [DIVW-1:0]  cpu_div_sel,
  output logic [2:0]       status_mode,
  output logic             status_busy,
  output logic             in_mgmt,
  output logic [NWAKE-1:0] wake_cause
);
  localparam int NDOM   = 6;
  localparam int CW     = $clog2(NDOM + 1);
  localparam int N_DOZE = 3;
  localparam int N_SLP  = 5;
  localparam int N_SUS  = NDOM;

  localparam logic [2:0] M_FULL = 3'd0;
  localparam logic [2:0] M_LOW  = 3'd1;
  localparam logic [2:0] M_DOZE = 3'd2;
  localparam logic [2:0] M_SLP  = 3'd3;
  localparam logic [2:0] M_SUS  = 3'd4;

  logic [2:0]       mode_q;
  logic             mgmt_q;
  logic [CW-1:0]    cur_n;
  logic [CW-1:0]    tgt_n;
  logic [NWAKE-1:0] cause_q;
  logic             wr_ok;
  logic             gated_mode;
  logic             wake_hit;

  function automatic logic [CW-1:0] gate_cnt(input logic [2:0] m);
    case (m)
      M_DOZE:  gate_cnt = CW'(N_DOZE);
      M_SLP:   gate_cnt = CW'(N_SLP);
      M_SUS:   gate_cnt = CW'(N_SUS);
      default: gate_cnt = '0;
    endcase
  endfunction

  assign wr_ok      = mode_wr && (mode_wdata <= M_SUS);
  assign gated_mode = (mode_q == M_DOZE) || (mode_q == M_SLP) || (mode_q == M_SUS);
  assign wake_hit   = !mgmt_q && gated_mode && |(wake_evt & wake_en);
  assign tgt_n      = mgmt_q ? '0 : gate_cnt(mode_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_n <= '0;
    end else if (cur_n < tgt_n) begin
      cur_n <= cur_n + CW'(1);
    end else if (cur_n > tgt_n) begin
      cur_n <= cur_n - CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= M_FULL;
      mgmt_q  <= 1'b0;
      cause_q <= '0;
    end else if (mgmt_irq && !mgmt_q) begin
      mgmt_q <= 1'b1;
    end else if (mgmt_q) begin
      if (resume_cmd) begin
        mgmt_q <= 1'b0;
      end else if (wr_ok) begin
        mode_q  <= mode_wdata;
        cause_q <= '0;
      end
    end else if (wake_hit) begin
      mode_q  <= M_FULL;
      cause_q <= cause_q | (wake_evt & wake_en);
    end else if (wr_ok) begin
      mode_q  <= mode_wdata;
      cause_q <= '0;
    end
  end

  for (genvar i = 0; i < NDOM; i++) begin : g_dom
    assign clk_en[i] = (CW'(i) >= cur_n);
  end

  assign rtc_clk_en  = 1'b1;
  assign mem_clk_en  = 1'b1;
  assign cpu_div_sel = (!mgmt_q && mode_q == M_LOW) ? DIVW'(LOW_DIV) : '0;
  assign status_mode = mode_q;
  assign status_busy = (cur_n != tgt_n);
  assign in_mgmt     = mgmt_q;
  assign wake_cause  = cause_q;
endmodule

module pwr_level_ctrl_chk #(
  parameter int NWAKE   = 4,
  parameter int DIVW    = 4,
  parameter int LOW_DIV = 9
) (
  input logic             clk,
  input logic             rst_n,
  input logic             mgmt_irq,
  input logic             resume_cmd,
  input logic [NWAKE-1:0] wake_evt,
  input logic [NWAKE-1:0] wake_en,
  input logic [5:0]       clk_en,
  input logic [DIVW-1:0]  cpu_div_sel,
  input logic [2:0]       status_mode,
  input logic             status_busy,
  input logic             in_mgmt
);
  logic [5:0] gated;
  assign gated = ~clk_en;

  p_thermo_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (gated & (gated + 6'd1)) == 6'd0);

  p_one_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(clk_en ^ $past(clk_en)) <= 1);

  p_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en != $past(clk_en)) |-> $past(status_busy));

  p_div_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_div_sel != '0) |-> (status_mode == 3'd1 && !in_mgmt && cpu_div_sel == DIVW'(LOW_DIV)));

  p_wake_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_mgmt && !mgmt_irq && status_mode >= 3'd2 && status_mode <= 3'd4 && |(wake_evt & wake_en))
    |=> (status_mode == 3'd0));

  p_mgmt_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_mgmt && !status_busy) |-> (&clk_en));

  p_mgmt_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_mgmt) |-> $stable(status_mode));

  p_resume_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_mgmt && resume_cmd) |=> !in_mgmt);
endmodule

bind pwr_level_ctrl pwr_level_ctrl_chk #(.NWAKE(NWAKE), .DIVW(DIVW), .LOW_DIV(LOW_DIV)) u_chk (.*);

// File: tb/test_pwr_level_ctrl.sv
module test_pwr_level_ctrl;
  localparam int NW   = 2;
  localparam int DW   = 4;
  localparam int LDIV = 9;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          mode_wr = 1'b0;
  logic [2:0]    mode_wdata = 3'd0;
  logic          mgmt_irq = 1'b0;
  logic          resume_cmd = 1'b0;
  logic [NW-1:0] wake_evt = '0;
  logic [NW-1:0] wake_en = '0;
  logic [5:0]    clk_en;
  logic          rtc_clk_en, mem_clk_en;
  logic [DW-1:0] cpu_div_sel;
  logic [2:0]    status_mode;
  logic          status_busy, in_mgmt;
  logic [NW-1:0] wake_cause;

  pwr_level_ctrl #(.NWAKE(NW), .DIVW(DW), .LOW_DIV(LDIV)) i_pwr_level_ctrl (.*);

  always #5 clk = ~clk;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  int            m_n = 0;
  logic [2:0]    m_mode = 3'd0;
  bit            m_mgmt = 0;
  logic [NW-1:0] m_cause = '0;

  function automatic int gcount(input logic [2:0] m);
    return (m == 3'd2) ? 3 : (m == 3'd3) ? 5 : (m == 3'd4) ? 6 : 0;
  endfunction

  function automatic int tgt();
    return m_mgmt ? 0 : gcount(m_mode);
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0d exp=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic tick();
    int t;
    logic [5:0] e;
    @(posedge clk);
    t = tgt();
    if (m_n < t) m_n++;
    else if (m_n > t) m_n--;
    if (mgmt_irq && !m_mgmt) m_mgmt = 1;
    else if (m_mgmt) begin
      if (resume_cmd) m_mgmt = 0;
      else if (mode_wr && mode_wdata <= 3'd4) begin m_mode = mode_wdata; m_cause = '0; end
    end else if (m_mode >= 3'd2 && m_mode <= 3'd4 && |(wake_evt & wake_en)) begin
      m_mode = 3'd0;
      m_cause = m_cause | (wake_evt & wake_en);
    end else if (mode_wr && mode_wdata <= 3'd4) begin
      m_mode = mode_wdata;
      m_cause = '0;
    end
    @(negedge clk);
    mode_wr = 0; mgmt_irq = 0; resume_cmd = 0; wake_evt = '0;
    e = 6'h3f;
    e = e << m_n;
    chk(clk_en == e, "R4 clk_en walk", clk_en, e);
    chk(status_busy == (m_n != tgt()), "R5 busy", status_busy, m_n != tgt());
    chk(cpu_div_sel == ((!m_mgmt && m_mode == 3'd1) ? DW'(LDIV) : '0), "R6 divider",
        cpu_div_sel, (!m_mgmt && m_mode == 3'd1) ? LDIV : 0);
    chk(status_mode == m_mode, "R2 mode", status_mode, m_mode);
    chk(in_mgmt == m_mgmt, "R8 in_mgmt", in_mgmt, m_mgmt);
    chk(wake_cause == m_cause, "R7 wake_cause", wake_cause, m_cause);
    chk(rtc_clk_en && mem_clk_en, "R10 rtc/mem enables", {rtc_clk_en, mem_clk_en}, 3);
  endtask

  task automatic settle();
    repeat (8) tick();
  endtask

  task automatic wr(input logic [2:0] m);
    mode_wr = 1; mode_wdata = m;
    tick();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(clk_en == 6'h3f && cpu_div_sel == 0 && !status_busy && !in_mgmt && wake_cause == 0
        && status_mode == 0, "R1 reset state", {status_mode, clk_en}, 6'h3f);

    // R2, R3, R4, R5, R6: every source mode against every written code
    for (int f = 0; f < 5; f++) begin
      for (int t = 0; t < 8; t++) begin
        wr(3'(f)); settle();
        wr(3'(t)); settle();
        chk($countones(~clk_en) == ((t < 5) ? gcount(3'(t)) : gcount(3'(f))),
            "R3 settled gate set", $countones(~clk_en), (t < 5) ? gcount(3'(t)) : gcount(3'(f)));
      end
    end

    // R4 redirect mid-sequence
    wr(3'd0); settle();
    wr(3'd4); tick(); tick();
    wr(3'd2); settle();
    wr(3'd3); tick();
    wr(3'd1); settle();
    chk(clk_en == 6'h3f, "R4 redirect end", clk_en, 6'h3f);

    // R7 wake sweep over modes, events and enables
    for (int m = 0; m < 5; m++) begin
      for (int ev = 0; ev < 4; ev++) begin
        for (int en = 0; en < 4; en++) begin
          wr(3'(m)); settle();
          wake_evt = NW'(ev); wake_en = NW'(en);
          tick();
          wake_en = '0;
          settle();
        end
      end
    end
    // wake during a partial entry, with cause accumulating
    wr(3'd4); tick();
    wake_en = 2'b01; wake_evt = 2'b01; tick();
    wr(3'd3); tick();
    settle();
    wake_en = 2'b11; wake_evt = 2'b10; tick();
    settle();

    // R8, R9 management from every mode
    for (int m = 0; m < 5; m++) begin
      wr(3'(m)); settle();
      mgmt_irq = 1; tick();
      settle();
      chk(in_mgmt && status_mode == 3'(m) && clk_en == 6'h3f, "R8 mgmt full clocks",
          {in_mgmt, status_mode}, {1'b1, 3'(m)});
      mgmt_irq = 1; tick();
      wake_en = 2'b11; wake_evt = 2'b11; tick();
      wake_en = '0;
      resume_cmd = 1; tick();
      settle();
      chk(!in_mgmt && status_mode == 3'(m), "R9 resume restores", status_mode, m);
    end
    // R9 write inside management replaces held mode
    wr(3'd2); settle();
    mgmt_irq = 1; tick();
    wr(3'd4); wr(3'd6);
    resume_cmd = 1; tick();
    settle();
    chk(status_mode == 3'd4 && clk_en == 6'h00, "R9 held mode replaced", status_mode, 4);
    resume_cmd = 1; tick();
    chk(status_mode == 3'd4 && !in_mgmt, "R9 resume outside ignored", status_mode, 4);

    // R11 precedence
    wake_en = 2'b01; wake_evt = 2'b01; mgmt_irq = 1; mode_wr = 1; mode_wdata = 3'd1; tick();
    chk(in_mgmt && status_mode == 3'd4, "R11 irq over wake and write", status_mode, 4);
    resume_cmd = 1; mode_wr = 1; mode_wdata = 3'd3; tick();
    chk(!in_mgmt && status_mode == 3'd4, "R11 resume over write", status_mode, 4);
    settle();
    wake_evt = 2'b01; mode_wr = 1; mode_wdata = 3'd1; tick();
    chk(status_mode == 3'd0 && wake_cause == 2'b01, "R11 wake over write", status_mode, 0);
    wake_en = '0;
    settle();

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R5 watchdog act=running exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule